// File: doc/BRIEF.md
# Four-Channel Timer Input Capture Unit

This block timestamps signal transitions. A 16-bit counter runs freely, advancing on every rising clock edge. Four capture channels each watch one input pin. A pin first passes through a two-flop synchroniser. Its synchronised level is then compared with the value from the previous cycle. When a transition of the polarity chosen for that channel appears, the channel copies the whole counter value into its own capture register in one transfer. That copy happens on the falling clock edge, which is the half-cycle opposite the counter update, so the counter is never caught mid-increment. Each capture also raises a sticky per-channel flag.

Channel 4 shares both its register and its pin with a compare function. It captures only while a mode bit selects capture. In that mode, bus writes to its register are ignored. A second mode bit can turn the shared pin into an output driven from a data bit. Edges created by writing that bit are then seen by channel 4 and captured, exactly like external edges.

An 8-bit register port gives access to the edge-control register, the mode bits, the flags and the byte-wide halves of each capture register. Reading a high byte freezes the matching low byte until that low byte is read. A 16-bit value read as two bytes therefore cannot be torn by a capture that lands between the two reads.

Top module: `tmr_capture_unit`

## Requirements
- R1: Each channel has a 2-bit edge field {B,A}: 00 = no capture, 01 = rising edges only, 10 = falling edges only, 11 = both edges. The edge-control register at address 0 places channel 4 in bits 7:6, channel 1 in bits 5:4, channel 2 in bits 3:2 and channel 3 in bits 1:0, with B as the upper bit of each pair.
- R2: After reset, the edge-control register (address 0), the mode register (address 1) and the flag register (address 2) read 0, and the counter output is 0. Capture registers are not reset.
- R3: A selected edge is captured as follows. The pin changes just after rising clock edge P. The capture register receives the counter value that is visible after edge P+2, latched on the following falling edge. Channel n's high byte is read at address 8+2*(n-1) and its low byte at address 9+2*(n-1).
- R4: Channels operate independently. Selected edges arriving together on several channels all store the same counter value.
- R5: Channel 4 captures only while mode bit 0 (capture select) is 1. With that bit at 0, edges on its pin set no flag and leave its register unchanged.
- R6: While capture select is 1, bus writes to channel 4's register (addresses 14 and 15) have no effect. While it is 0, those writes store the written byte.
- R7: Mode bit 1 makes the shared pin an output and mode bit 2 is its data. These appear on the pin-output enable and pin-output ports. While mode bit 1 is 1, channel 4 watches mode bit 2 instead of the external pin, and its selected edges are captured.
- R8: Flag register bit n-1 is set by a capture on channel n. Writing 1 to a flag bit clears it. A capture in the same cycle as a clear leaves the flag set.
- R9: Reading a capture high byte holds that channel's low byte. The next low-byte read returns the held byte even if a capture occurred in between. A later low-byte read returns the live value.
- R10: The counter advances by one per clock and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter and registers on rising edge, captures on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe (drives the low-byte hold) |
| busRdData | output | 8 | Read data for busAddr |
| capPins | input | 4 | Capture inputs, bit n-1 for channel n |
| sharedPinOut | output | 1 | Drive value for the shared channel-4 pin |
| sharedPinOutEn | output | 1 | Output enable for the shared channel-4 pin |
| capFlags | output | 4 | Capture flags, bit n-1 for channel n |
| timerCount | output | 16 | Free-running counter value |

## Verification
Two kinds of event can fall on the same clock edge. The first is a capture setting a flag while software writes 1 to clear that same flag. The second is selected edges on several channels arriving together. The bench times a flag-clear write so that it lands on the very edge where a channel-3 capture sets the flag, and judges that the flag stays set. It also raises all four pins in one cycle, and judges that every enabled channel holds the identical counter value while the channel whose field ignores rising edges stays clear.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int NCH = 4;           // capture channels
  localparam int CW  = 16;          // counter width
  localparam int BW  = 8;           // bus width
  localparam int CHW = $clog2(NCH);

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic [2*NCH-1:0] edgeSel;      // channel-ordered edge fields
    logic             capSel;       // shared slot in capture mode
    logic             pinDir;       // shared pin driven as output
    logic             pinData;      // shared pin drive value
    logic             wrShHi;       // bus write to shared register high byte
    logic             wrShLo;       // bus write to shared register low byte
    logic [BW-1:0]    wrByte;
  } tcapStrobe_t;
endpackage

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pinIn,
  input  tcapStrobe_t       strb,
  output logic [NCH-1:0]    capEvent,
  output logic [NCH*CW-1:0] capFlat,
  output logic [CW-1:0]     count
);
  logic [NCH-1:0] effPin, syncA, syncB, prevB;

  assign effPin = {strb.pinDir ? strb.pinData : pinIn[NCH-1], pinIn[NCH-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
      count <= '0;
    end else begin
      syncA <= effPin;
      syncB <= syncA;
      prevB <= syncB;
      count <= count + CW'(1);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [1:0]    sel;
    logic          chEn;
    logic [CW-1:0] capReg;

    assign sel  = strb.edgeSel[2*g +: 2];
    assign chEn = (g == NCH-1) ? strb.capSel : 1'b1;
    assign capEvent[g] = chEn && ((sel[0] && syncB[g] && !prevB[g]) ||
                                  (sel[1] && !syncB[g] && prevB[g]));

    if (g == NCH-1) begin : g_shared
      always_ff @(negedge clk) begin
        if (capEvent[g]) capReg <= count;
        else if (!strb.capSel) begin
          if (strb.wrShHi) capReg[CW-1 -: BW] <= strb.wrByte;
          if (strb.wrShLo) capReg[BW-1:0]     <= strb.wrByte;
        end
      end
    end else begin : g_plain
      always_ff @(negedge clk) begin
        if (capEvent[g]) capReg <= count;
      end
    end

    assign capFlat[g*CW +: CW] = capReg;

    assert_field_off_R1: assert property (@(posedge clk) disable iff (rst)
      (sel == 2'b00) |-> !capEvent[g]);
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (count == $past(count) + CW'(1)));

  assert_shared_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !strb.capSel |-> !capEvent[NCH-1]);
endmodule

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BW-1:0]     wrData,
  input  logic              rdEn,
  output logic [BW-1:0]     rdData,
  input  logic [NCH-1:0]    capEvent,
  input  logic [NCH*CW-1:0] capFlat,
  output tcapStrobe_t       strb,
  output logic [NCH-1:0]    flags,
  output logic              pinOut,
  output logic              pinOutEn
);
  localparam logic [ADDR_W-1:0] EDGE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SH_HI     = ADDR_W'(8 + 2*(NCH-1));
  localparam logic [ADDR_W-1:0] SH_LO     = ADDR_W'(9 + 2*(NCH-1));

  logic [BW-1:0]    edgeReg;
  logic [2:0]       modeReg;
  logic [NCH-1:0]   flagReg, clrMask;
  logic [BW-1:0]    holdByte [NCH];
  logic [NCH-1:0]   holdFlag;
  logic [2*NCH-1:0] edgeMap;
  logic             capSpace, hiSel;
  logic [CHW-1:0]   chSel;

  assign capSpace = addr[ADDR_W-1];
  assign chSel    = addr[CHW:1];
  assign hiSel    = !addr[0];

  // channel 4 field sits on top, channels 1..3 follow downward
  for (genvar g = 0; g < NCH; g++) begin : g_map
    localparam int POS = (g == NCH-1) ? BW-2 : BW-4-2*g;
    assign edgeMap[2*g +: 2] = edgeReg[POS +: 2];
  end

  always_comb begin
    strb.edgeSel = edgeMap;
    strb.capSel  = modeReg[0];
    strb.pinDir  = modeReg[1];
    strb.pinData = modeReg[2];
    strb.wrShHi  = wrEn && (addr == SH_HI);
    strb.wrShLo  = wrEn && (addr == SH_LO);
    strb.wrByte  = wrData;
  end

  assign clrMask = (wrEn && addr == FLAG_ADDR) ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      edgeReg  <= '0;
      modeReg  <= '0;
      flagReg  <= '0;
      holdFlag <= '0;
      for (int i = 0; i < NCH; i++) holdByte[i] <= '0;
    end else begin
      if (wrEn && addr == EDGE_ADDR) edgeReg <= wrData;
      if (wrEn && addr == MODE_ADDR) modeReg <= wrData[2:0];
      flagReg <= (flagReg & ~clrMask) | capEvent;
      if (rdEn && capSpace) begin
        if (hiSel) begin
          holdByte[chSel] <= capFlat[chSel*CW +: BW];
          holdFlag[chSel] <= 1'b1;
        end else begin
          holdFlag[chSel] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (capSpace)
      rdData = hiSel ? capFlat[chSel*CW + BW +: BW]
                     : (holdFlag[chSel] ? holdByte[chSel] : capFlat[chSel*CW +: BW]);
    else if (addr == EDGE_ADDR) rdData = edgeReg;
    else if (addr == MODE_ADDR) rdData = {{(BW-3){1'b0}}, modeReg};
    else if (addr == FLAG_ADDR) rdData = {{(BW-NCH){1'b0}}, flagReg};
  end

  assign flags    = flagReg;
  assign pinOut   = modeReg[2];
  assign pinOutEn = modeReg[1];

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    (capEvent != '0) |=> ((flagReg & $past(capEvent)) == $past(capEvent)));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == FLAG_ADDR && (capEvent & wrData[NCH-1:0]) == '0)
      |=> ((flagReg & $past(wrData[NCH-1:0])) == '0));

  assert_hold_arm_R9: assert property (@(posedge clk) disable iff (rst)
    (rdEn && capSpace && hiSel) |=> holdFlag[$past(chSel)]);
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import tcap_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BW-1:0]     busWrData,
  input  logic              busRd,
  output logic [BW-1:0]     busRdData,
  input  logic [NCH-1:0]    capPins,
  output logic              sharedPinOut,
  output logic              sharedPinOutEn,
  output logic [NCH-1:0]    capFlags,
  output logic [CW-1:0]     timerCount
);
  tcapStrobe_t       strb;
  logic [NCH-1:0]    capEvent;
  logic [NCH*CW-1:0] capFlat;

  tcap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .addr(busAddr), .wrEn(busWr), .wrData(busWrData),
    .rdEn(busRd), .rdData(busRdData), .capEvent(capEvent), .capFlat(capFlat),
    .strb(strb), .flags(capFlags), .pinOut(sharedPinOut), .pinOutEn(sharedPinOutEn)
  );

  tcap_datapath u_dp (
    .clk(clk), .rst(rst), .pinIn(capPins), .strb(strb),
    .capEvent(capEvent), .capFlat(capFlat), .count(timerCount)
  );
endmodule

// File: tb/tmr_capture_unit_test.sv
module tmr_capture_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [3:0]  pins = '0;
  logic        pinOut, pinOutEn;
  logic [3:0]  flags;
  logic [15:0] count;

  int checkCnt = 0;
  int failCnt  = 0;

  string      reqQ[$];
  logic [7:0] valQ[$];
  logic [7:0] gotVal;
  event       gotEvt;

  logic [15:0] e3, e5, e6, e8;

  tmr_capture_unit uut (
    .clk(clk), .rst(rst), .busAddr(addr), .busWr(wrEn), .busWrData(wrData),
    .busRd(rdEn), .busRdData(rdData), .capPins(pins), .sharedPinOut(pinOut),
    .sharedPinOutEn(pinOutEn), .capFlags(flags), .timerCount(count)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
    checkCnt++;
    if (act !== want) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, want);
    end
  endtask

  // scoreboard monitor: pops expected read data as results arrive
  initial forever begin
    @(gotEvt);
    if (reqQ.size() == 0) check("queue", 32'(gotVal), 32'hDEAD);
    else begin
      string r;
      logic [7:0] w;
      r = reqQ.pop_front();
      w = valQ.pop_front();
      check(r, 32'(gotVal), 32'(w));
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk) #1 addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk) #1 wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [3:0] a, input logic [7:0] want, input string req);
    reqQ.push_back(req);
    valQ.push_back(want);
    @(posedge clk) #1 addr = a; rdEn = 1'b1;
    #3 gotVal = rdData;
    -> gotEvt;
    @(posedge clk) #1 rdEn = 1'b0;
  endtask

  // apply a pin pattern; return the counter value seen after the second edge
  task automatic pinEdge(input logic [3:0] p, output logic [15:0] stamp);
    @(posedge clk) #1 pins = p;
    @(posedge clk);
    @(posedge clk) #1 stamp = count;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    #1500000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] junk;
    repeat (3) @(posedge clk);
    #1 check("R2 counter in reset", 32'(count), 0);
    rst = 1'b0;
    expectRead(4'd0, 8'h00, "R2 edge reg");
    expectRead(4'd1, 8'h00, "R2 mode reg");
    expectRead(4'd2, 8'h00, "R2 flag reg");

    // ch4 rising (7:6=01), ch1 rising (5:4=01), ch2 falling (3:2=10), ch3 both (1:0=11)
    busWrite(4'd0, 8'h5B);
    busWrite(4'd1, 8'h01);
    pinEdge(4'b1111, e3);
    check("R1 R4 flags after rise", 32'(flags), 32'b1101);
    expectRead(4'd8,  e3[15:8], "R3 ch1 hi");
    expectRead(4'd9,  e3[7:0],  "R3 ch1 lo");
    expectRead(4'd12, e3[15:8], "R4 ch3 hi");
    expectRead(4'd13, e3[7:0],  "R4 ch3 lo");
    expectRead(4'd15, e3[7:0],  "R4 ch4 lo");
    busWrite(4'd2, 8'h0F);
    check("R8 flags cleared", 32'(flags), 0);

    pinEdge(4'b0000, e5);
    check("R1 flags after fall", 32'(flags), 32'b0110);
    expectRead(4'd10, e5[15:8], "R1 ch2 falling hi");
    busWrite(4'd2, 8'h0F);

    // R9: low byte held across a capture between the byte reads
    expectRead(4'd10, e5[15:8], "R9 ch2 hi");
    pinEdge(4'b0010, junk);
    check("R1 ch2 ignores rise", 32'(flags), 0);
    pinEdge(4'b0000, e6);
    expectRead(4'd11, e5[7:0],  "R9 held lo");
    expectRead(4'd10, e6[15:8], "R9 new hi");
    expectRead(4'd11, e6[7:0],  "R9 new lo");
    busWrite(4'd2, 8'h0F);

    // R6: shared register in capture mode ignores writes
    busWrite(4'd14, 8'hAB);
    busWrite(4'd15, 8'hCD);
    expectRead(4'd14, e3[15:8], "R6 hi write ignored");
    expectRead(4'd15, e3[7:0],  "R6 lo write ignored");
    busWrite(4'd1, 8'h00);
    busWrite(4'd14, 8'h12);
    busWrite(4'd15, 8'h34);
    expectRead(4'd14, 8'h12, "R6 compare hi stored");
    expectRead(4'd15, 8'h34, "R6 compare lo stored");

    // R5: compare mode, edge on shared pin has no effect
    pinEdge(4'b1000, junk);
    check("R5 no flag in compare mode", 32'(flags), 0);
    expectRead(4'd14, 8'h12, "R5 register unchanged");

    // R7: pin as output; falling to data 0 is not selected
    busWrite(4'd1, 8'h03);
    repeat (4) @(posedge clk);
    #1 check("R7 falling not captured", 32'(flags[3]), 0);
    check("R7 output enable", 32'(pinOutEn), 1);
    @(posedge clk) #1 addr = 4'd1; wrData = 8'h07; wrEn = 1'b1;
    @(posedge clk) #1 wrEn = 1'b0;
    @(posedge clk);
    @(posedge clk) #1 e8 = count;
    repeat (2) @(posedge clk);
    #1 check("R7 pin out value", 32'(pinOut), 1);
    check("R7 flag from written pin", 32'(flags[3]), 1);
    expectRead(4'd14, e8[15:8], "R7 capture hi");
    expectRead(4'd15, e8[7:0],  "R7 capture lo");

    // R8: clear lands on the same edge as a set
    busWrite(4'd2, 8'h0F);
    @(posedge clk) #1 pins[2] = 1'b1;
    @(posedge clk);
    @(posedge clk) #1 addr = 4'd2; wrData = 8'h04; wrEn = 1'b1;
    @(posedge clk) #1 wrEn = 1'b0;
    check("R8 set wins over clear", 32'(flags[2]), 1);

    // R10: wrap
    for (int i = 0; i < 70000; i++) begin
      @(posedge clk) #1;
      if (count == 16'hFFFF) begin
        @(posedge clk) #1 check("R10 wrap to zero", 32'(count), 0);
        break;
      end
    end

    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule